// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block connects two 18-bit buses, A and B, and passes data between them in both directions. Each direction has one storage stage. Its latch enable picks how that stage behaves. With the latch enable high the stage is transparent, so the destination port follows the source port. With it low the stage holds its value, and a rising edge on that direction's strobe loads the source data. Each direction also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. A disabled port is released, which means its drive-enable vector is cleared.

Three-state pins are modelled as a data-out vector and a per-bit drive-enable vector for each port. The bus data, the strobes, the latch enables and the output enables all arrive asynchronously. A system clock samples all of them through one common pipeline of equal depth, so their relative timing is kept. The strobe rising edges are detected inside the system clock domain. The host chip wires the drive-enable vectors to its pad three-state controls. A contention flag is raised when both ports are driven at the same time.

Top module: `bus_xcvr_top`

## Requirements
- R1: Both directions carry the full 18-bit word, and each direction has its own storage, latch enable, strobe and output enable, so any bit pattern passes unchanged in either direction at the same time.
- R2: While a direction's latch enable is high, its destination data output follows its source data input.
- R3: While a direction's latch enable is low and its strobe stays at a steady level, the destination data output keeps its stored value whatever the source data does.
- R4: While a direction's latch enable is low, a 0-to-1 change of its strobe loads the source data present at that edge into storage.
- R5: When the latch enable falls, the stored value is the source data sampled in the last cycle in which the latch enable was still high. A later change of the source data does not reach the output.
- R6: The A-to-B output enable is active high. When it is 1, every bit of `b_drive` is 1. When it is 0, every bit of `b_drive` is 0.
- R7: The B-to-A output enable is active low. When it is 0, every bit of `a_drive` is 1. When it is 1, every bit of `a_drive` is 0.
- R8: Every input passes through `SYNC_STAGES` sampling registers and then one storage register. A change at the inputs therefore shows at the outputs exactly `SYNC_STAGES`+1 system clock edges later, and not before.
- R9: A synchronous reset clears both stored words to zero and clears both drive-enable vectors. The drive enables stay clear until enable values sampled after reset have passed through the pipeline.
- R10: `contention` is 1 exactly when `a_drive` and `b_drive` are both asserted. Each port's drive still follows only its own enable.
- R11: A strobe rising edge that arrives while the latch enable is high changes nothing beyond the transparent behaviour: the output still equals the current source data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data sampled from the A bus |
| b_in | input | 18 | Data sampled from the B bus |
| ab_le | input | 1 | A-to-B latch enable; 1 = transparent |
| ab_strobe | input | 1 | A-to-B load strobe; acts on its rising edge |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable; 1 = transparent |
| ba_strobe | input | 1 | B-to-A load strobe; acts on its rising edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Data the B port drives |
| b_drive | output | 18 | Per-bit drive enable for the B port |
| a_out | output | 18 | Data the A port drives |
| a_drive | output | 18 | Per-bit drive enable for the A port |
| contention | output | 1 | Both ports are driven at once |

## Verification
The bench builds the block with its default values, WIDTH of 18 and SYNC_STAGES of 2. With two sampling stages the three-edge latency of R8 can be checked at the exact cycle. At full width the R1 patterns cover every bit. The sweep walks all 64 combinations of the six control levels twice, once in counting order and once in a scrambled order. Each combination is therefore reached from several different predecessors, and that exercises latch-enable falls, strobe edges in both modes, simultaneous control changes and every enable pairing. Expected words, drives and the contention flag come from a step-level model that applies R2 to R5 and R11.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Action taken by a direction's storage stage in a given cycle.
  typedef enum logic [1:0] {
    LM_PASS = 2'd0,  // latch enable high: follow the source
    LM_HOLD = 2'd1,  // latch enable low, no strobe edge
    LM_LOAD = 2'd2   // latch enable low, strobe rising edge
  } lane_mode_e;
endpackage

// File: rtl/xcvr_sample_pipe.sv
module xcvr_sample_pipe #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 18,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] src,
  input  logic             le,
  input  logic             strobe,
  input  logic             oe_act,
  output logic [WIDTH-1:0] dst,
  output logic [WIDTH-1:0] drive
);
  localparam int PW = WIDTH + 3;

  logic [PW-1:0]    pin, pout;
  logic [WIDTH-1:0] s_data, stored;
  logic             s_le, s_strobe, s_oe, strobe_prev, rise, oe_q;
  lane_mode_e       mode;

  // Data and controls share one pipeline so their relative timing is kept.
  assign pin = {oe_act, strobe, le, src};

  xcvr_sample_pipe #(.WIDTH(PW), .STAGES(STAGES)) u_pipe (
    .clk (clk),
    .rst (rst),
    .d   (pin),
    .q   (pout)
  );

  assign s_data   = pout[WIDTH-1:0];
  assign s_le     = pout[WIDTH];
  assign s_strobe = pout[WIDTH+1];
  assign s_oe     = pout[WIDTH+2];

  always_ff @(posedge clk) begin
    if (rst) strobe_prev <= 1'b0;
    else     strobe_prev <= s_strobe;
  end

  assign rise = s_strobe & ~strobe_prev;

  always_comb begin
    if (s_le)      mode = LM_PASS;
    else if (rise) mode = LM_LOAD;
    else           mode = LM_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stored <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= s_oe;
      case (mode)
        LM_PASS, LM_LOAD: stored <= s_data;
        default:          stored <= stored;
      endcase
    end
  end

  assign dst   = stored;
  assign drive = {WIDTH{oe_q}};

  a_r2_pass_follows: assert property (@(posedge clk) disable iff (rst)
    s_le |=> (stored == $past(s_data)));
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (!s_le && !(s_strobe && !strobe_prev)) |=> $stable(stored));
  a_r4_edge_loads: assert property (@(posedge clk) disable iff (rst)
    (!s_le && s_strobe && !strobe_prev) |=> (stored == $past(s_data)));
  a_r8_rise_single: assert property (@(posedge clk) disable iff (rst)
    (s_strobe && !strobe_prev) |=> !(s_strobe && !strobe_prev));
  a_r6_drive_uniform: assert property (@(posedge clk) disable iff (rst)
    (drive == '0) || (drive == '1));
endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top #(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ab_le,
  input  logic             ab_strobe,
  input  logic             ab_oe,
  input  logic             ba_le,
  input  logic             ba_strobe,
  input  logic             ba_oe_n,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_drive,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_drive,
  output logic             contention
);
  // A to B: enable is active high.
  xcvr_lane #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_ab (
    .clk    (clk),
    .rst    (rst),
    .src    (a_in),
    .le     (ab_le),
    .strobe (ab_strobe),
    .oe_act (ab_oe),
    .dst    (b_out),
    .drive  (b_drive)
  );

  // B to A: enable is active low, so it is inverted at the lane input.
  xcvr_lane #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_ba (
    .clk    (clk),
    .rst    (rst),
    .src    (b_in),
    .le     (ba_le),
    .strobe (ba_strobe),
    .oe_act (~ba_oe_n),
    .dst    (a_out),
    .drive  (a_drive)
  );

  assign contention = a_drive[0] & b_drive[0];

  a_r10_contention_both: assert property (@(posedge clk) disable iff (rst)
    contention |-> ((a_drive == '1) && (b_drive == '1)));
  a_r9_reset_released: assert property (@(posedge clk)
    $past(rst) |-> ((a_drive == '0) && (b_drive == '0) && !contention));
endmodule

// File: tb/sim_bus_xcvr_top.sv
module sim_bus_xcvr_top;
  localparam int W = 18;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_in, b_out, b_drive, a_out, a_drive;
  logic ab_le, ab_strobe, ab_oe, ba_le, ba_strobe, ba_oe_n, contention;

  always #5 clk = ~clk;

  bus_xcvr_top #(.WIDTH(W), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_strobe(ab_strobe), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_strobe(ba_strobe), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive),
    .contention(contention)
  );

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  // Bench model state
  logic [W-1:0] m_ab, m_ba;
  logic p_ab_le, p_ab_st, p_ba_le, p_ba_st;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic le, input logic ple, input logic rise);
    if (le) return rise ? "R11" : "R2";
    if (rise) return "R4";
    if (ple) return "R5";
    return "R3";
  endfunction

  task automatic step(input logic [W-1:0] da, input logic [W-1:0] db,
                      input logic l1, input logic c1, input logic o1,
                      input logic l2, input logic c2, input logic on2);
    logic r1, r2;
    string t1, t2;
    @(negedge clk);
    a_in = da; b_in = db;
    ab_le = l1; ab_strobe = c1; ab_oe = o1;
    ba_le = l2; ba_strobe = c2; ba_oe_n = on2;
    r1 = c1 & ~p_ab_st;
    r2 = c2 & ~p_ba_st;
    t1 = tag_of(l1, p_ab_le, r1);
    t2 = tag_of(l2, p_ba_le, r2);
    if (l1 || r1) m_ab = da;
    if (l2 || r2) m_ba = db;
    p_ab_le = l1; p_ab_st = c1; p_ba_le = l2; p_ba_st = c2;
    repeat (SYNC + 2) @(negedge clk);
    chk({t1, " b_out"}, b_out, m_ab);
    chk({t2, " a_out"}, a_out, m_ba);
    chk("R6 b_drive", b_drive, o1 ? '1 : '0);
    chk("R7 a_drive", a_drive, on2 ? '0 : '1);
    chk("R10 contention", {{(W-1){1'b0}}, contention}, {{(W-1){1'b0}}, (o1 & ~on2)});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x1, x2;
    rst = 1'b1;
    a_in = 18'h15A5A; b_in = 18'h0F0F0;
    ab_le = 1'b1; ab_strobe = 1'b0; ab_oe = 1'b1;
    ba_le = 1'b1; ba_strobe = 1'b0; ba_oe_n = 1'b0;
    m_ab = '0; m_ba = '0;
    p_ab_le = 1'b0; p_ab_st = 1'b0; p_ba_le = 1'b0; p_ba_st = 1'b0;
    repeat (4) @(negedge clk);
    // R9: reset state with enables requested
    chk("R9 b_drive in reset", b_drive, '0);
    chk("R9 a_drive in reset", a_drive, '0);
    chk("R9 b_out in reset", b_out, '0);
    chk("R9 a_out in reset", a_out, '0);
    ab_le = 1'b0; ba_le = 1'b0; ab_oe = 1'b0; ba_oe_n = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    chk("R9 b_drive after reset", b_drive, '0);
    chk("R9 a_drive after reset", a_drive, '0);
    chk("R9 contention after reset", {{(W-1){1'b0}}, contention}, '0);

    // R8: exact latency through the pipeline
    step(18'h12345, 18'h0ABCD, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    x2 = 18'h3C3C3;
    @(negedge clk);
    a_in = x2;
    m_ab = x2;
    x1 = 18'h12345;
    repeat (SYNC) @(negedge clk);
    chk("R8 not before latency", b_out, x1);
    @(negedge clk);
    chk("R8 at latency", b_out, x2);

    // R1: full-width patterns in both directions at once
    step('1, 18'h2AAAA, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    step(18'h15555, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R1 b_out pattern", b_out, 18'h15555);
    chk("R1 a_out pattern", a_out, 18'h00000);

    // R5: latch enable falls with strobe high, then data moves
    step(18'h0F00F, 18'h30303, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    step(18'h0F00F, 18'h30303, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    step(18'h21212, 18'h01234, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R5 b_out kept", b_out, 18'h0F00F);
    // R4 and R11 explicit
    step(18'h21212, 18'h01234, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step(18'h21212, 18'h01234, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R4 b_out loaded", b_out, 18'h21212);
    step(18'h33333, 18'h11111, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    step(18'h33333, 18'h11111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R11 b_out unchanged", b_out, 18'h33333);

    // Sweep of all control combinations, two orders
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 64; k++) begin
        int code;
        logic [W-1:0] da, db;
        code = (pass == 0) ? k : ((k * 37 + 11) % 64);
        da = W'((k * 32'h1357 + pass * 32'h9A1) ^ 32'h2AAAA);
        db = W'((k * 32'h0B6D + pass * 32'h4C7) ^ 32'h15555);
        step(da, db, code[0], code[1], code[2], code[3], code[4], code[5]);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule